// File: doc/BRIEF.md
# Programmable SCL Timing Generator

This block produces the serial clock for a two-wire bus master, together with a strobe that tells the data-line driver when it may change SDA. Two sets of high/low durations are held at the inputs, one for standard speed and one for fast speed. A two-bit speed selector picks which set is used. All durations are counted in system clock cycles.

Within each low phase of SCL, the SDA update strobe fires a programmable number of clocks after the falling edge. That hold delay is limited so that it always lands inside the low phase. A setup count can stretch the low phase, so that SDA stays valid for a minimum number of clocks before SCL rises.

Single-cycle pulses mark every SCL rising and falling edge for the surrounding sequencer. When the enable is low, the block is parked with SCL high and every counter cleared. START/STOP framing, clock stretching and arbitration are handled elsewhere.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and right after it, `scl_o` is 1 and `scl_rise_o`, `scl_fall_o` and `sda_upd_o` are 0.
- R2: While `enable` is 0, `scl_o` is 1 and no pulse or strobe is produced. Dropping `enable` during a low phase returns `scl_o` to 1 on the next clock without a rise pulse. After re-enabling, SCL first stays high for the full selected high count, counting the cycle in which `enable` was set.
- R3: When `speed_sel` is not 2 (this covers the codes 0, 1 and 3, where 1 means standard), SCL stays high for `std_hi_cnt` clocks and low for `std_lo_cnt` clocks, unless R7 lengthens the low phase.
- R4: When `speed_sel` equals 2 (fast), SCL stays high for `fast_hi_cnt` clocks and low for `fast_lo_cnt` clocks, unless R7 lengthens the low phase.
- R5: `scl_fall_o` is high for exactly the first clock of each low phase, and `scl_rise_o` is high for exactly the first clock of each high phase that follows a low phase. No other clocks carry these pulses.
- R6: `sda_upd_o` fires once per low phase, H clocks after the clock that carries the fall pulse. H is `sda_hold_cnt`, except when `sda_hold_cnt` is greater than or equal to the selected low count L; then H is L-1.
- R7: The low phase lasts max(L, H + `sda_setup_cnt`) clocks, so the strobe comes at least `sda_setup_cnt` clocks before the next rise.
- R8: A high or low count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 runs the generator, 0 parks it |
| speed_sel | input | 2 | 2 selects the fast pair; any other value selects the standard pair |
| std_hi_cnt | input | CNT_W | Standard-speed high duration |
| std_lo_cnt | input | CNT_W | Standard-speed low duration |
| fast_hi_cnt | input | CNT_W | Fast-speed high duration |
| fast_lo_cnt | input | CNT_W | Fast-speed low duration |
| sda_hold_cnt | input | CNT_W | Clocks from SCL fall to the SDA update strobe |
| sda_setup_cnt | input | CNT_W | Minimum clocks from the SDA strobe to SCL rise |
| scl_o | output | 1 | Serial clock level |
| sda_upd_o | output | 1 | One-clock strobe: SDA may change now |
| scl_rise_o | output | 1 | One-clock pulse on each SCL rising edge |
| scl_fall_o | output | 1 | One-clock pulse on each SCL falling edge |

## Verification
The bench builds the block with CNT_W = 8. This keeps the periods short enough to sweep every speed code, both zero-count clamps and the smallest one-clock phases within a few thousand cycles. At this width, a hold of 255 plus a setup of 255 drives the stretched low phase to 509 clocks. That is past the count range and needs the extra internal bit, so the wide-sum path is exercised at the real top of the range.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  // Speed selector codes
  localparam logic [1:0] SPD_STD  = 2'd1;
  localparam logic [1:0] SPD_FAST = 2'd2;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } scl_phase_t;

  // Pair index used by the count selector
  localparam int unsigned PAIR_STD  = 0;
  localparam int unsigned PAIR_FAST = 1;
  localparam int unsigned NUM_PAIRS = 2;

endpackage

// File: rtl/scl_cfg_sel.sv
module scl_cfg_sel
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       speed_sel,
  input  logic [CNT_W-1:0] std_hi_cnt,
  input  logic [CNT_W-1:0] std_lo_cnt,
  input  logic [CNT_W-1:0] fast_hi_cnt,
  input  logic [CNT_W-1:0] fast_lo_cnt,
  input  logic [CNT_W-1:0] sda_hold_cnt,
  input  logic [CNT_W-1:0] sda_setup_cnt,
  output logic [CNT_W:0]   hi_len,
  output logic [CNT_W:0]   lo_len,
  output logic [CNT_W-1:0] hold_eff
);

  localparam int unsigned LW = CNT_W + 1;

  logic [CNT_W-1:0] raw_hi [NUM_PAIRS];
  logic [CNT_W-1:0] raw_lo [NUM_PAIRS];
  logic [CNT_W-1:0] cl_hi  [NUM_PAIRS];
  logic [CNT_W-1:0] cl_lo  [NUM_PAIRS];

  assign raw_hi[PAIR_STD]  = std_hi_cnt;
  assign raw_lo[PAIR_STD]  = std_lo_cnt;
  assign raw_hi[PAIR_FAST] = fast_hi_cnt;
  assign raw_lo[PAIR_FAST] = fast_lo_cnt;

  // Zero durations are promoted to one clock (R8)
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_clamp
    always_comb begin
      cl_hi[g] = (raw_hi[g] == '0) ? CNT_W'(1) : raw_hi[g];
      cl_lo[g] = (raw_lo[g] == '0) ? CNT_W'(1) : raw_lo[g];
    end
  end

  logic             use_fast;
  logic [CNT_W-1:0] hi_sel;
  logic [CNT_W-1:0] lo_sel;
  logic [LW-1:0]    need_lo;

  always_comb begin
    use_fast = (speed_sel == SPD_FAST);
    hi_sel   = use_fast ? cl_hi[PAIR_FAST] : cl_hi[PAIR_STD];
    lo_sel   = use_fast ? cl_lo[PAIR_FAST] : cl_lo[PAIR_STD];
    // Hold may not reach the end of the low phase (R6)
    if (sda_hold_cnt >= lo_sel) begin
      hold_eff = lo_sel - CNT_W'(1);
    end else begin
      hold_eff = sda_hold_cnt;
    end
    // Setup stretch computed one bit wider than the counts (R7)
    need_lo = {1'b0, hold_eff} + {1'b0, sda_setup_cnt};
    lo_len  = (need_lo > {1'b0, lo_sel}) ? need_lo : {1'b0, lo_sel};
    hi_len  = {1'b0, hi_sel};
  end

  // R6
  hold_inside_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_len > {1'b0, hold_eff});

  // R7
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_len - {1'b0, hold_eff}) >= {1'b0, sda_setup_cnt});

  // R8
  nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len != '0) && (lo_len != '0));

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W:0]   hi_len,
  input  logic [CNT_W:0]   lo_len,
  input  logic [CNT_W-1:0] hold_eff,
  output logic             scl,
  output logic             sda_upd,
  output logic             rise,
  output logic             fall
);

  localparam int unsigned LW = CNT_W + 1;

  scl_phase_t       phase_q, phase_d;
  logic [LW-1:0]    cnt_q,   cnt_d;
  logic [LW-1:0]    term_q,  term_d;
  logic [CNT_W-1:0] hold_q,  hold_d;
  logic             rise_q,  rise_d;
  logic             fall_q,  fall_d;
  logic             at_term;
  logic             cnt_ld;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    term_d  = term_q;
    hold_d  = hold_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    at_term = (cnt_q == term_q);
    cnt_ld  = 1'b1;
    if (!en) begin
      // Parked: SCL high, counters cleared, next high phase pre-loaded
      phase_d = PH_HIGH;
      cnt_d   = '0;
      term_d  = hi_len - LW'(1);
      hold_d  = '0;
    end else if (at_term) begin
      cnt_d = '0;
      if (phase_q == PH_HIGH) begin
        phase_d = PH_LOW;
        term_d  = lo_len - LW'(1);
        hold_d  = hold_eff;
        fall_d  = 1'b1;
      end else begin
        phase_d = PH_HIGH;
        term_d  = hi_len - LW'(1);
        rise_d  = 1'b1;
      end
    end else begin
      cnt_d = cnt_q + LW'(1);
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      term_q  <= '0;
      hold_q  <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else if (cnt_ld) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      term_q  <= term_d;
      hold_q  <= hold_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign scl     = (phase_q == PH_HIGH);
  assign rise    = rise_q;
  assign fall    = fall_q;
  assign sda_upd = (phase_q == PH_LOW) && (cnt_q == {1'b0, hold_q});

  // R5
  rise_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (scl && !$past(scl)));

  // R5
  fall_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!scl && $past(scl)));

  // R5
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_q, fall_q}));

  // R2
  parked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !rise_q && !fall_q && !sda_upd));

  // R6
  strobe_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd |-> !scl);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       speed_sel,
  input  logic [CNT_W-1:0] std_hi_cnt,
  input  logic [CNT_W-1:0] std_lo_cnt,
  input  logic [CNT_W-1:0] fast_hi_cnt,
  input  logic [CNT_W-1:0] fast_lo_cnt,
  input  logic [CNT_W-1:0] sda_hold_cnt,
  input  logic [CNT_W-1:0] sda_setup_cnt,
  output logic             scl_o,
  output logic             sda_upd_o,
  output logic             scl_rise_o,
  output logic             scl_fall_o
);

  logic [CNT_W:0]   hi_len;
  logic [CNT_W:0]   lo_len;
  logic [CNT_W-1:0] hold_eff;

  scl_cfg_sel #(.CNT_W(CNT_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .speed_sel     (speed_sel),
    .std_hi_cnt    (std_hi_cnt),
    .std_lo_cnt    (std_lo_cnt),
    .fast_hi_cnt   (fast_hi_cnt),
    .fast_lo_cnt   (fast_lo_cnt),
    .sda_hold_cnt  (sda_hold_cnt),
    .sda_setup_cnt (sda_setup_cnt),
    .hi_len        (hi_len),
    .lo_len        (lo_len),
    .hold_eff      (hold_eff)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .hi_len   (hi_len),
    .lo_len   (lo_len),
    .hold_eff (hold_eff),
    .scl      (scl_o),
    .sda_upd  (sda_upd_o),
    .rise     (scl_rise_o),
    .fall     (scl_fall_o)
  );

endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;

  localparam int CW = 8;
  localparam int NV = 10;
  localparam int LIM = 3000;

  // sel, std_hi, std_lo, fast_hi, fast_lo, hold, setup, exp_hi, exp_lo, exp_hold
  localparam int VT [NV][10] = '{
    '{1,   3,   5,   2,   2,   2,   0,   3,   5,   2},
    '{2,   9,   9,   2,   3,   1,   0,   2,   3,   1},
    '{0,   4,   4,   7,   7,   0,   0,   4,   4,   0},
    '{3,   6,   2,   1,   1,   7,   0,   6,   2,   1},
    '{2,   5,   5,   1,   1,   0,   0,   1,   1,   0},
    '{1,   0,   0,   3,   3,   0,   0,   1,   1,   0},
    '{1,   3,   4,   2,   2,   2,   5,   3,   7,   2},
    '{1,   3,  10,   2,   2,   2,   3,   3,  10,   2},
    '{1,   2,   3,   2,   2,   9,   4,   2,   6,   2},
    '{2,   9,   9, 200, 255, 255, 255, 200, 509, 254}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] speed_sel = 2'd1;
  logic [CW-1:0] std_hi = '0, std_lo = '0, fst_hi = '0, fst_lo = '0;
  logic [CW-1:0] hold = '0, setup = '0;
  logic scl, sda_upd, rise, fall;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scl_timing_gen #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
    .std_hi_cnt(std_hi), .std_lo_cnt(std_lo),
    .fast_hi_cnt(fst_hi), .fast_lo_cnt(fst_lo),
    .sda_hold_cnt(hold), .sda_setup_cnt(setup),
    .scl_o(scl), .sda_upd_o(sda_upd), .scl_rise_o(rise), .scl_fall_o(fall)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic string vtag(input int i);
    case (i)
      1, 4, 9: return "R4";
      3:       return "R6";
      5:       return "R8";
      6, 7, 8: return "R7";
      default: return "R3";
    endcase
  endfunction

  // Measure one full SCL period starting at a fall pulse
  task automatic measure(output int lo, output int hi, output int hoff,
                         output int nstr, output int perr, output int ok);
    int t;
    lo = -1; hi = -1; hoff = -1; nstr = 0; perr = 0; ok = 1;
    t = 0;
    while (!fall && t < LIM) begin step(); t++; end
    if (t >= LIM) begin ok = 0; return; end
    t = 0;
    forever begin
      if (sda_upd) begin nstr++; hoff = t; end
      if (scl !== 1'b0) perr++;
      if (t > 0 && fall) perr++;
      step(); t++;
      if (rise) begin lo = t; break; end
      if (t >= LIM) begin ok = 0; return; end
    end
    t = 0;
    forever begin
      if (scl !== 1'b1 || sda_upd) perr++;
      if (t > 0 && rise) perr++;
      step(); t++;
      if (fall) begin hi = t; break; end
      if (t >= LIM) begin ok = 0; return; end
    end
  endtask

  initial begin
    int lo, hi, hoff, nstr, perr, ok, cnt;
    // R1: reset state
    step(); step();
    check("R1", "scl in reset", int'(scl), 1);
    check("R1", "pulses in reset", int'({rise, fall, sda_upd}), 0);
    rst_n = 1'b1;
    step();
    check("R1", "scl after reset", int'(scl), 1);
    check("R1", "pulses after reset", int'({rise, fall, sda_upd}), 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      enable = 1'b0;
      speed_sel = VT[i][0][1:0];
      std_hi = VT[i][1][CW-1:0]; std_lo = VT[i][2][CW-1:0];
      fst_hi = VT[i][3][CW-1:0]; fst_lo = VT[i][4][CW-1:0];
      hold = VT[i][5][CW-1:0];   setup = VT[i][6][CW-1:0];
      step(); step();
      enable = 1'b1;
      measure(lo, hi, hoff, nstr, perr, ok);
      check(vtag(i), $sformatf("vec%0d measured", i), ok, 1);
      check(vtag(i), $sformatf("vec%0d high len", i), hi, VT[i][7]);
      check(vtag(i), $sformatf("vec%0d low len", i), lo, VT[i][8]);
      check("R6", $sformatf("vec%0d hold offset", i), hoff, VT[i][9]);
      check("R6", $sformatf("vec%0d strobes", i), nstr, 1);
      check("R5", $sformatf("vec%0d pulse/level errors", i), perr, 0);
    end

    // R2: parked state
    enable = 1'b0;
    speed_sel = 2'd1; std_hi = 8'd5; std_lo = 8'd8; hold = 8'd1; setup = 8'd0;
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      step();
      if (!scl || rise || fall || sda_upd) cnt++;
    end
    check("R2", "parked bad samples", cnt, 0);

    // R2: restart gives full high phase
    enable = 1'b1;
    cnt = 1;
    forever begin
      step();
      if (scl && cnt < LIM) cnt++; else break;
    end
    check("R2", "first high after enable", cnt, 5);
    check("R5", "fall pulse at first low", int'(fall), 1);

    // R2: disable in the middle of a low phase
    step(); step();
    check("R2", "still low before disable", int'(scl), 0);
    enable = 1'b0;
    step();
    check("R2", "scl high after disable", int'(scl), 1);
    check("R2", "no rise pulse on disable", int'(rise), 0);
    step();
    check("R2", "idle next cycle", int'({rise, fall, sda_upd}), 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule